// File: doc/BRIEF.md
# Glitch-Free Multi-Bank Clock Divider

The block takes one fast source clock and derives four divided clocks from it: three banks (A, B and C) of four outputs each, and one feedback output. Each bank's ratio comes from a 2-bit select code. The feedback ratio comes from a 3-bit select code whose top bit is ignored. A shared `fast_mode` control halves every ratio at once, so the relationships between the banks are kept. The select inputs may change at any time while the block runs. Every output still shows only complete periods, each at either the old ratio or the new one.

Each output channel is a small state machine that runs on the source clock. Its states are `PH_IDLE` (held in reset), `PH_HIGH` (counting the high half) and `PH_LOW` (counting the low half). Its transitions are:
- idle→high on the first source edge after reset is released, which loads the ratio;
- high→low when the half-period count expires;
- low→high when the count expires, which ends the period and loads a freshly sampled ratio.

An active-low master reset/output enable clears every flip-flop and holds all outputs low. When `inv_c_hi` is high, outputs 2 and 3 of bank C are driven inverted.

Top module: `glitchfree_clkdiv`

## Requirements
- R1: With `fast_mode`=0, `sel_a` codes 00, 01, 10 and 11 give source periods of 4, 12, 8 and 24 on every `qa` bit.
- R2: With `fast_mode`=0, `sel_b` codes 00, 01, 10 and 11 give periods of 4, 12, 8 and 20 on every `qb` bit.
- R3: With `fast_mode`=0, `sel_c` codes 00, 01, 10 and 11 give periods of 16, 4, 12 and 8 on every `qc` bit.
- R4: With `fast_mode`=1, every bank ratio and the feedback ratio are half their `fast_mode`=0 values.
- R5: `sel_fb[1:0]` codes 00, 01, 10 and 11 give `fb_out` periods of 8, 12, 16 and 20 (halved under R4). `sel_fb[2]` has no effect.
- R6: A select or `fast_mode` change is applied only at the end of the period in progress. That period finishes at the old ratio and the next one uses the new ratio, so no runt or stretched period appears.
- R7: While `rst_n_oe` is low, all outputs are low and all dividers are held at their start.
- R8: While running, `qc[3:2]` equal the inverse of `qc[1:0]` when `inv_c_hi` was high on the previous source edge, and are equal to them when it was low.
- R9: On the first source edge after `rst_n_oe` rises, every non-inverted output rises together.
- R10: Each period is high for exactly half the ratio and low for the other half. Outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n_oe | input | 1 | Active-low master reset and output enable (asynchronous) |
| fast_mode | input | 1 | 1 halves every ratio |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| sel_c | input | 2 | Bank C ratio code |
| sel_fb | input | 3 | Feedback ratio code, bit 2 ignored |
| inv_c_hi | input | 1 | Inverts qc[3:2] when high |
| qa | output | 4 | Bank A clocks |
| qb | output | 4 | Bank B clocks |
| qc | output | 4 | Bank C clocks, [3:2] invertible |
| fb_out | output | 1 | Feedback clock |

## Verification
The bench attacks select changes that arrive mid-period, including changes on the very edge where a period ends, and changes to `fast_mode` that alter every bank at once. A design that applied a new code immediately would show a short or long period, which the period monitor catches against the ratio captured at the previous rising edge. Toggling `sel_fb[2]` would visibly change `fb_out` in a design that decoded all three bits. A reset pulse in the middle of a run checks that outputs drop low at once and that all banks restart on a common edge; an off-by-one in the reload would instead skew the first edge or shorten the first half period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        BANK_A  = 2'd0,
        BANK_B  = 2'd1,
        BANK_C  = 2'd2,
        BANK_FB = 2'd3
    } bank_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    // Half-period length in source cycles with the halving control low.
    function automatic int unsigned slow_half(bank_e bank, logic [2:0] code);
        int unsigned h;
        h = 2;
        unique case (bank)
            BANK_A: begin
                unique case (code[1:0])
                    2'b00: h = 2;
                    2'b01: h = 6;
                    2'b10: h = 4;
                    default: h = 12;
                endcase
            end
            BANK_B: begin
                unique case (code[1:0])
                    2'b00: h = 2;
                    2'b01: h = 6;
                    2'b10: h = 4;
                    default: h = 10;
                endcase
            end
            BANK_C: begin
                unique case (code[1:0])
                    2'b00: h = 8;
                    2'b01: h = 2;
                    2'b10: h = 6;
                    default: h = 4;
                endcase
            end
            default: begin
                // All eight codes decoded; bit 2 selects nothing.
                unique case (code)
                    3'b000, 3'b100: h = 4;
                    3'b001, 3'b101: h = 6;
                    3'b010, 3'b110: h = 8;
                    default:        h = 10;
                endcase
            end
        endcase
        return h;
    endfunction

endpackage

// File: rtl/ratio_lookup.sv
module ratio_lookup
    import clkdiv_pkg::*;
#(
    parameter bank_e BANK  = BANK_A,
    parameter int    SEL_W = 2,
    parameter int    CNT_W = 4
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             fast,
    output logic [CNT_W-1:0] half
);

    logic [2:0]  code;
    int unsigned base;

    always_comb begin
        code = 3'(sel);
        base = slow_half(BANK, code);
        half = fast ? CNT_W'(base / 2) : CNT_W'(base);
    end

endmodule

// File: rtl/bank_divider.sv
module bank_divider
    import clkdiv_pkg::*;
#(
    parameter bank_e          BANK     = BANK_A,
    parameter int             SEL_W    = 2,
    parameter int             CNT_W    = 4,
    parameter int             NUM_OUT  = 4,
    parameter logic [NUM_OUT-1:0] INV_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fast,
    input  logic [SEL_W-1:0]   sel,
    input  logic               inv,
    output logic [NUM_OUT-1:0] out
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_e           state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [CNT_W-1:0] half_q, half_nx;
    logic [CNT_W-1:0] half_new;
    logic             hi_q;

    ratio_lookup #(
        .BANK  (BANK),
        .SEL_W (SEL_W),
        .CNT_W (CNT_W)
    ) u_lookup (
        .sel  (sel),
        .fast (fast),
        .half (half_new)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            half_q  <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
            half_q  <= half_nx;
        end
    end

    // Next-state logic: the ratio is reloaded only when a period closes.
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        half_nx  = half_q;
        unique case (state_q)
            PH_IDLE: begin
                state_nx = PH_HIGH;
                half_nx  = half_new;
                cnt_nx   = half_new - ONE;
            end
            PH_HIGH: begin
                if (cnt_q == '0) begin
                    state_nx = PH_LOW;
                    cnt_nx   = half_q - ONE;
                end else begin
                    cnt_nx = cnt_q - ONE;
                end
            end
            PH_LOW: begin
                if (cnt_q == '0) begin
                    state_nx = PH_HIGH;
                    half_nx  = half_new;
                    cnt_nx   = half_new - ONE;
                end else begin
                    cnt_nx = cnt_q - ONE;
                end
            end
            default: begin
                state_nx = PH_IDLE;
                cnt_nx   = '0;
                half_nx  = '0;
            end
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_q <= 1'b0;
        else        hi_q <= (state_nx == PH_HIGH);
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out[i] <= 1'b0;
            else        out[i] <= (state_nx == PH_HIGH) ^ (inv & INV_MASK[i]);
        end
    end

    // ---------------- checker state and assertions ----------------
    logic             hi_prev;
    logic [CNT_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_prev <= 1'b0;
            run_len <= '0;
        end else begin
            hi_prev <= hi_q;
            run_len <= (hi_q == hi_prev) ? run_len + ONE : ONE;
        end
    end

    AST_RATIO_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(half_q) |-> $rose(hi_q)); // R6

    AST_LOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hi_q) && $past(half_q) != '0) |-> run_len == $past(half_q)); // R6

    AST_HIGH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hi_q) |-> run_len == half_q); // R10

    always @(posedge clk) begin
        if (!rst_n) AST_HELD_LOW: assert (out == '0); // R7
    end

endmodule

// File: rtl/glitchfree_clkdiv.sv
module glitchfree_clkdiv
    import clkdiv_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int CNT_W   = 4
) (
    input  logic               clk_src,
    input  logic               rst_n_oe,
    input  logic               fast_mode,
    input  logic [1:0]         sel_a,
    input  logic [1:0]         sel_b,
    input  logic [1:0]         sel_c,
    input  logic [2:0]         sel_fb,
    input  logic               inv_c_hi,
    output logic [NUM_OUT-1:0] qa,
    output logic [NUM_OUT-1:0] qb,
    output logic [NUM_OUT-1:0] qc,
    output logic               fb_out
);

    localparam logic [NUM_OUT-1:0] C_INV = {2'b11, {(NUM_OUT-2){1'b0}}};

    logic [0:0] fb_vec;

    bank_divider #(.BANK(BANK_A), .SEL_W(2), .CNT_W(CNT_W), .NUM_OUT(NUM_OUT),
                   .INV_MASK('0)) u_bank_a (
        .clk(clk_src), .rst_n(rst_n_oe), .fast(fast_mode), .sel(sel_a),
        .inv(inv_c_hi), .out(qa));

    bank_divider #(.BANK(BANK_B), .SEL_W(2), .CNT_W(CNT_W), .NUM_OUT(NUM_OUT),
                   .INV_MASK('0)) u_bank_b (
        .clk(clk_src), .rst_n(rst_n_oe), .fast(fast_mode), .sel(sel_b),
        .inv(inv_c_hi), .out(qb));

    bank_divider #(.BANK(BANK_C), .SEL_W(2), .CNT_W(CNT_W), .NUM_OUT(NUM_OUT),
                   .INV_MASK(C_INV)) u_bank_c (
        .clk(clk_src), .rst_n(rst_n_oe), .fast(fast_mode), .sel(sel_c),
        .inv(inv_c_hi), .out(qc));

    bank_divider #(.BANK(BANK_FB), .SEL_W(3), .CNT_W(CNT_W), .NUM_OUT(1),
                   .INV_MASK(1'b0)) u_bank_fb (
        .clk(clk_src), .rst_n(rst_n_oe), .fast(fast_mode), .sel(sel_fb),
        .inv(inv_c_hi), .out(fb_vec));

    assign fb_out = fb_vec[0];

    // ---------------- checker state and assertions ----------------
    logic started_q;
    logic any_hi, all_hi;

    assign any_hi = qa[0] | qb[0] | qc[0] | fb_out;
    assign all_hi = qa[0] & qb[0] & qc[0] & fb_out;

    always_ff @(posedge clk_src or negedge rst_n_oe) begin
        if (!rst_n_oe)   started_q <= 1'b0;
        else if (any_hi) started_q <= 1'b1;
    end

    AST_COMMON_START: assert property (@(posedge clk_src) disable iff (!rst_n_oe)
        (!started_q && any_hi) |-> all_hi); // R9

    AST_INV_TRACK: assert property (@(posedge clk_src) disable iff (!rst_n_oe)
        $past(rst_n_oe) |-> qc[NUM_OUT-1:NUM_OUT-2] ==
            ({2{qc[0]}} ^ {2{$past(inv_c_hi)}})); // R8

endmodule

// File: tb/tb_glitchfree_clkdiv.sv
module tb_glitchfree_clkdiv;

    logic       clk = 1'b0;
    logic       rst_n_oe, fast_mode, inv_c_hi;
    logic [1:0] sel_a, sel_b, sel_c;
    logic [2:0] sel_fb;
    logic [3:0] qa, qb, qc;
    logic       fb_out;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    glitchfree_clkdiv dut (
        .clk_src(clk), .rst_n_oe(rst_n_oe), .fast_mode(fast_mode),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
        .inv_c_hi(inv_c_hi), .qa(qa), .qb(qb), .qc(qc), .fb_out(fb_out));

    // Full period in source cycles, from the requirement tables.
    function automatic int period_of(int bank, int code, bit fast);
        int p;
        case (bank)
            0: p = (code == 0) ? 4  : (code == 1) ? 12 : (code == 2) ? 8  : 24;
            1: p = (code == 0) ? 4  : (code == 1) ? 12 : (code == 2) ? 8  : 20;
            2: p = (code == 0) ? 16 : (code == 1) ? 4  : (code == 2) ? 12 : 8;
            default: p = 8 + 4 * (code % 4);
        endcase
        return fast ? p / 2 : p;
    endfunction

    function automatic int code_of(int bank);
        case (bank)
            0: return int'(sel_a);
            1: return int'(sel_b);
            2: return int'(sel_c);
            default: return int'(sel_fb);
        endcase
    endfunction

    function automatic string tag_of(int bank);
        if (bank == 0) return fast_mode ? "R1,R4" : "R1";
        if (bank == 1) return fast_mode ? "R2,R4" : "R2";
        if (bank == 2) return fast_mode ? "R3,R4" : "R3";
        return fast_mode ? "R5,R4" : "R5";
    endfunction

    // Behavioural reference model, advanced on every source edge.
    bit run_m;
    int ph_m  [4];
    int rat_m [4];
    bit inv_m;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n_oe) begin
            run_m = 0;
        end else if (!run_m) begin
            run_m = 1;
            for (int b = 0; b < 4; b++) begin
                ph_m[b]  = 0;
                rat_m[b] = period_of(b, code_of(b), fast_mode);
            end
        end else begin
            for (int b = 0; b < 4; b++) begin
                ph_m[b]++;
                if (ph_m[b] == rat_m[b]) begin
                    ph_m[b]  = 0;
                    rat_m[b] = period_of(b, code_of(b), fast_mode);
                end
            end
        end
        inv_m = inv_c_hi;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d (expected finish earlier)", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d",
                     req, what, cyc, act, exp);
        end
    endtask

    // Period / duty monitor state (R6, R10)
    bit prev_o  [4];
    int rise_at [4];
    int per_exp [4];

    function automatic bit raw_out(int bank);
        case (bank)
            0: return qa[0];
            1: return qb[0];
            2: return qc[0];
            default: return fb_out;
        endcase
    endfunction

    bit just_released = 0;

    // Called at a falling edge, before inputs change.
    task automatic compare();
        bit e [4];
        for (int b = 0; b < 4; b++) e[b] = run_m && (ph_m[b] < rat_m[b] / 2);

        if (!run_m) begin
            check({qa, qb, qc, fb_out} == 13'd0, "R7", "outputs in reset",
                  int'({qa, qb, qc, fb_out}), 0);
        end else begin
            check(qa === {4{e[0]}}, tag_of(0), "qa", int'(qa), int'({4{e[0]}}));
            check(qb === {4{e[1]}}, tag_of(1), "qb", int'(qb), int'({4{e[1]}}));
            check(qc[1:0] === {2{e[2]}}, tag_of(2), "qc[1:0]",
                  int'(qc[1:0]), int'({2{e[2]}}));
            check(qc[3:2] === {2{e[2] ^ inv_m}}, "R8", "qc[3:2]",
                  int'(qc[3:2]), int'({2{e[2] ^ inv_m}}));
            check(fb_out === e[3], tag_of(3), "fb_out", int'(fb_out), int'(e[3]));
        end

        if (just_released) begin
            check({qa[0], qb[0], qc[0], fb_out} == 4'hF, "R9", "common first edge",
                  int'({qa[0], qb[0], qc[0], fb_out}), 15);
            just_released = 0;
        end

        for (int b = 0; b < 4; b++) begin
            bit o;
            o = raw_out(b);
            if (!run_m) begin
                prev_o[b]  = 0;
                per_exp[b] = 0;
            end else begin
                if (o && !prev_o[b]) begin
                    if (per_exp[b] != 0)
                        check(cyc - rise_at[b] == per_exp[b], "R6", "period length",
                              cyc - rise_at[b], per_exp[b]);
                    rise_at[b] = cyc;
                    per_exp[b] = period_of(b, code_of(b), fast_mode);
                end else if (!o && prev_o[b] && per_exp[b] != 0) begin
                    check(cyc - rise_at[b] == per_exp[b] / 2, "R10", "high length",
                          cyc - rise_at[b], per_exp[b] / 2);
                end
                prev_o[b] = o;
            end
        end
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic random_run(int n, bit vary_fast);
        for (int i = 0; i < n; i++) begin
            step(1);
            if ($urandom_range(0, 5) == 0) begin
                case ($urandom_range(0, 4))
                    0: sel_a  = 2'($urandom);
                    1: sel_b  = 2'($urandom);
                    2: sel_c  = 2'($urandom);
                    3: sel_fb = 3'($urandom);
                    default: inv_c_hi = ~inv_c_hi;
                endcase
            end
            if (vary_fast && $urandom_range(0, 40) == 0) fast_mode = ~fast_mode;
        end
    endtask

    initial begin
        rst_n_oe = 0; fast_mode = 0; inv_c_hi = 0;
        sel_a = 0; sel_b = 0; sel_c = 0; sel_fb = 0;
        step(4);
        rst_n_oe = 1; just_released = 1;

        // Fixed sweep of every code in both modes (R1..R5 tables)
        for (int f = 0; f < 2; f++) begin
            for (int c = 0; c < 4; c++) begin
                fast_mode = f[0];
                sel_a = 2'(c); sel_b = 2'(c); sel_c = 2'(c); sel_fb = 3'(c);
                step(60);
                sel_fb[2] = 1'b1;   // R5: top bit must not matter
                step(60);
            end
        end

        inv_c_hi = 1;               // R8
        step(40);

        random_run(6000, 0);        // R6 with select changes only
        random_run(6000, 1);        // R6 with halving changes too

        rst_n_oe = 0;               // R7 mid-run reset
        step(5);
        sel_a = 2'd3; sel_b = 2'd1; sel_c = 2'd0; sel_fb = 3'd6; fast_mode = 0;
        rst_n_oe = 1; just_released = 1;   // R9
        step(100);

        random_run(4000, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule